// File: doc/BRIEF.md
# Correlation Peak Finder and Search Window Tracker

The block takes a correlation map one score per cycle, in raster order, and keeps the best score seen in the current frame along with the coordinates where it was found. When the frame closes, it turns that position into absolute array coordinates. It then moves the origin of the square search window so that the peak lands on the window's centre cell for the next frame. The window origin always stays far enough from the array border that a full 7x7 template fits around every cell of the window.

Two modes are supported. In acquisition mode the score source sweeps the entire sensor array and supplies absolute coordinates. In tracking mode it supplies only the small window and gives coordinates relative to the window origin. A completed acquisition scan puts the block into tracking. A software-requested reacquire switches it back to acquisition. So does a tracking frame whose peak falls under an optional minimum score. Computing and normalizing the scores are handled elsewhere.

Top module: `peak_tracker`

## Requirements
- R1: After reset the window origin is (MARGIN, MARGIN), `tracking` is 0 (acquisition), `upd` is 0, and the peak outputs are 0.
- R2: The frame peak is the largest `smp_score` among cycles with `smp_valid` high. A later sample replaces the stored peak only if it is strictly larger, so on a tie the first one in raster order is kept (rows top to bottom, columns left to right).
- R3: `frm_start` discards the previous frame's running maximum. A sample that arrives in the same cycle as `frm_end` is not counted.
- R4: In acquisition mode (`tracking`=0), sample coordinates are absolute. At frame end the new origin is the peak minus HALF (where HALF = WIN/2) on each axis, after clamping, and `tracking` becomes 1.
- R5: In tracking mode (`tracking`=1), sample coordinates are relative to the window, in the range 0..WIN-1. The reported peak is origin + local position, and the new origin is that absolute peak minus HALF on each axis, after clamping.
- R6: Each origin coordinate is clamped to the range [MARGIN, ARR-MARGIN-WIN].
- R7: In tracking mode, if `thr_en` is 1 and the frame peak is below `min_score`, the block goes back to acquisition and leaves the origin unchanged. A peak equal to `min_score` keeps tracking.
- R8: `upd` is high for exactly the one cycle after the clock edge that samples `frm_end`, and only if the frame held at least one valid sample. In that cycle `pk_x`, `pk_y` and `pk_score` show the frame's absolute peak, and the origin shows its new value.
- R9: `reacq` forces acquisition at the next edge, drops the running maximum and leaves the origin unchanged. It takes priority over a `frm_end` in the same cycle, so no update happens.
- R10: A cycle with `smp_valid` low has no effect on the peak, whatever its score and coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Start of a map frame; clears the running maximum |
| frm_end | input | 1 | End of a map frame; triggers the origin update |
| smp_valid | input | 1 | Marks a valid map sample |
| smp_x | input | CW | Sample column (absolute in acquisition, window-local in tracking) |
| smp_y | input | CW | Sample row (absolute in acquisition, window-local in tracking) |
| smp_score | input | SW | Correlation score |
| reacq | input | 1 | Force a return to acquisition |
| thr_en | input | 1 | Enable the minimum-score check in tracking |
| min_score | input | SW | Minimum acceptable tracking peak |
| win_x | output | CW | Window origin column |
| win_y | output | CW | Window origin row |
| pk_x | output | CW | Absolute column of last frame peak |
| pk_y | output | CW | Absolute row of last frame peak |
| pk_score | output | SW | Score of last frame peak |
| upd | output | 1 | One-cycle update strobe |
| tracking | output | 1 | 1 in tracking mode, 0 in acquisition |

## Verification
The frame result has one register stage after `frm_end`. The bench drives `frm_end` on a falling edge, and the following rising edge loads the origin, the peak outputs, the mode and `upd` together. The bench therefore reads all of them at the next falling edge, and reads again one falling edge later to confirm that `upd` has dropped. A reacquire request appears on `tracking` at the falling edge after the rising edge that samples it. A reacquire that comes together with `frm_end` is confirmed by seeing `upd` low and the origin unchanged at that same point.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic {
    MODE_ACQ = 1'b0,
    MODE_TRK = 1'b1
  } pt_mode_e;
endpackage

// File: rtl/pt_peak_hold.sv
module pt_peak_hold #(
  parameter int CW = 10,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          vld,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [SW-1:0] score,
  output logic          have,
  output logic [CW-1:0] bx,
  output logic [CW-1:0] by,
  output logic [SW-1:0] bs
);
  logic          have_n;
  logic [CW-1:0] bx_n, by_n;
  logic [SW-1:0] bs_n;
  logic          take;

  // strict greater-than keeps the earliest of equal scores
  assign take = vld && (start || !have || (score > bs));

  always_comb begin
    have_n = have;
    bx_n   = bx;
    by_n   = by;
    bs_n   = bs;
    if (stop) begin
      have_n = 1'b0;
    end else if (take) begin
      have_n = 1'b1;
      bx_n   = x;
      by_n   = y;
      bs_n   = score;
    end else if (start) begin
      have_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= 1'b0;
      bx   <= '0;
      by   <= '0;
      bs   <= '0;
    end else begin
      have <= have_n;
      bx   <= bx_n;
      by   <= by_n;
      bs   <= bs_n;
    end
  end
endmodule

// File: rtl/pt_axis_step.sv
module pt_axis_step #(
  parameter int CW   = 10,
  parameter int HALF = 12,
  parameter int LO   = 3,
  parameter int HI   = 996
) (
  input  logic          acq,
  input  logic [CW-1:0] org,
  input  logic [CW-1:0] loc,
  output logic [CW-1:0] abs_o,
  output logic [CW-1:0] nxt_o
);
  localparam logic signed [CW+1:0] HALF_S = (CW+2)'(HALF);
  localparam logic signed [CW+1:0] LO_S   = (CW+2)'(LO);
  localparam logic signed [CW+1:0] HI_S   = (CW+2)'(HI);

  logic signed [CW+1:0] a_s, t_s;

  always_comb begin
    if (acq) a_s = $signed({2'b00, loc});
    else     a_s = $signed({2'b00, org} + {2'b00, loc});
    t_s   = a_s - HALF_S;
    abs_o = a_s[CW-1:0];
    if (t_s < LO_S)      nxt_o = LO_S[CW-1:0];
    else if (t_s > HI_S) nxt_o = HI_S[CW-1:0];
    else                 nxt_o = t_s[CW-1:0];
  end
endmodule

// File: rtl/peak_tracker.sv
module peak_tracker
  import pt_pkg::*;
#(
  parameter int ARR    = 1024,
  parameter int WIN    = 25,
  parameter int MARGIN = 3,
  parameter int SW     = 16,
  localparam int CW    = $clog2(ARR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_start,
  input  logic          frm_end,
  input  logic          smp_valid,
  input  logic [CW-1:0] smp_x,
  input  logic [CW-1:0] smp_y,
  input  logic [SW-1:0] smp_score,
  input  logic          reacq,
  input  logic          thr_en,
  input  logic [SW-1:0] min_score,
  output logic [CW-1:0] win_x,
  output logic [CW-1:0] win_y,
  output logic [CW-1:0] pk_x,
  output logic [CW-1:0] pk_y,
  output logic [SW-1:0] pk_score,
  output logic          upd,
  output logic          tracking
);
  localparam int HALF   = WIN / 2;
  localparam int ORG_LO = MARGIN;
  localparam int ORG_HI = ARR - MARGIN - WIN;

  pt_mode_e      mode_q, mode_n;
  logic          have;
  logic [CW-1:0] bx, by;
  logic [SW-1:0] bs;
  logic [CW-1:0] org_q   [2];
  logic [CW-1:0] org_n   [2];
  logic [CW-1:0] loc     [2];
  logic [CW-1:0] abs_pk  [2];
  logic [CW-1:0] nxt_org [2];
  logic [CW-1:0] pk_q    [2];
  logic [CW-1:0] pk_n    [2];
  logic [SW-1:0] pks_n;
  logic          upd_n;
  logic          below;

  pt_peak_hold #(.CW(CW), .SW(SW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .start (frm_start),
    .stop  (frm_end | reacq),
    .vld   (smp_valid),
    .x     (smp_x),
    .y     (smp_y),
    .score (smp_score),
    .have  (have),
    .bx    (bx),
    .by    (by),
    .bs    (bs)
  );

  assign loc[0] = bx;
  assign loc[1] = by;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    pt_axis_step #(.CW(CW), .HALF(HALF), .LO(ORG_LO), .HI(ORG_HI)) u_step (
      .acq   (mode_q == MODE_ACQ),
      .org   (org_q[g]),
      .loc   (loc[g]),
      .abs_o (abs_pk[g]),
      .nxt_o (nxt_org[g])
    );
  end

  assign below = (mode_q == MODE_TRK) && thr_en && (bs < min_score);

  always_comb begin
    mode_n = mode_q;
    org_n  = org_q;
    pk_n   = pk_q;
    pks_n  = pk_score;
    upd_n  = 1'b0;
    if (reacq) begin
      mode_n = MODE_ACQ;
    end else if (frm_end && have) begin
      upd_n = 1'b1;
      pk_n  = abs_pk;
      pks_n = bs;
      if (below) begin
        mode_n = MODE_ACQ;
      end else begin
        mode_n = MODE_TRK;
        org_n  = nxt_org;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_ACQ;
      org_q[0] <= CW'(ORG_LO);
      org_q[1] <= CW'(ORG_LO);
      pk_q[0]  <= '0;
      pk_q[1]  <= '0;
      pk_score <= '0;
      upd      <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      org_q    <= org_n;
      pk_q     <= pk_n;
      pk_score <= pks_n;
      upd      <= upd_n;
    end
  end

  assign win_x    = org_q[0];
  assign win_y    = org_q[1];
  assign pk_x     = pk_q[0];
  assign pk_y     = pk_q[1];
  assign tracking = (mode_q == MODE_TRK);
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int CW = 10,
  parameter int LO = 3,
  parameter int HI = 996
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_end,
  input logic          reacq,
  input logic          upd,
  input logic          tracking,
  input logic [CW-1:0] win_x,
  input logic [CW-1:0] win_y
);
  p_upd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  p_upd_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(frm_end) && !$past(reacq));

  p_org_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(win_x) >= LO) && (int'(win_x) <= HI) &&
    (int'(win_y) >= LO) && (int'(win_y) <= HI));

  p_org_moves_on_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(win_x) || !$stable(win_y)) |-> upd);

  p_reacq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reacq |=> !tracking && !upd);

  p_acq_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !$past(tracking)) |-> tracking);

  p_drop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && $past(tracking) && !tracking) |-> ($stable(win_x) && $stable(win_y)));
endmodule

bind peak_tracker pt_checker #(.CW(CW), .LO(ORG_LO), .HI(ORG_HI)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frm_end  (frm_end),
  .reacq    (reacq),
  .upd      (upd),
  .tracking (tracking),
  .win_x    (win_x),
  .win_y    (win_y)
);

// File: tb/tb_peak_tracker.sv
module tb_peak_tracker;
  localparam int ARR = 32, WIN = 5, MARGIN = 3, SW = 8, CW = 5;
  localparam int HALF = WIN / 2, LO = MARGIN, HI = ARR - MARGIN - WIN;

  logic clk, rst_n, frm_start, frm_end, smp_valid, reacq, thr_en;
  logic [CW-1:0] smp_x, smp_y, win_x, win_y, pk_x, pk_y;
  logic [SW-1:0] smp_score, min_score, pk_score;
  logic upd, tracking;

  int n_run, n_fail, cyc;
  int m_ox, m_oy, m_trk;

  peak_tracker #(.ARR(ARR), .WIN(WIN), .MARGIN(MARGIN), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_score(smp_score),
    .reacq(reacq), .thr_en(thr_en), .min_score(min_score),
    .win_x(win_x), .win_y(win_y), .pk_x(pk_x), .pk_y(pk_y),
    .pk_score(pk_score), .upd(upd), .tracking(tracking));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int clampc(input int v);
    if (v < LO) return LO;
    if (v > HI) return HI;
    return v;
  endfunction

  // one frame: high score hv at (px,py), qv at (qx,qy), filler elsewhere
  task automatic frame(input int px, input int py, input int qx, input int qy,
                       input int hv, input int qv, input int thr_on, input int thr);
    int n, bx, by, bs, ax, ay, s;
    n  = m_trk ? WIN : ARR;
    bs = -1; bx = 0; by = 0;
    thr_en = thr_on[0]; min_score = SW'(thr);
    tick(); frm_start = 1'b1;
    // R10: invalid cycle carrying a huge score
    tick(); frm_start = 1'b0; smp_valid = 1'b0; smp_x = 5'd1; smp_y = 5'd1; smp_score = 8'd255;
    for (int y = 0; y < n; y++) begin
      for (int x = 0; x < n; x++) begin
        s = (x * 3 + y * 5) % 16;
        if (x == px && y == py) s = hv;
        if (x == qx && y == qy) s = qv;
        if (s > bs) begin bs = s; bx = x; by = y; end
        tick(); smp_valid = 1'b1; smp_x = CW'(x); smp_y = CW'(y); smp_score = SW'(s);
      end
    end
    // R3: sample coinciding with frm_end must be dropped
    tick(); frm_end = 1'b1; smp_valid = 1'b1; smp_score = 8'd254;
    tick(); frm_end = 1'b0; smp_valid = 1'b0;
    ax = m_trk ? m_ox + bx : bx;
    ay = m_trk ? m_oy + by : by;
    if (m_trk && thr_on != 0 && bs < thr) begin
      m_trk = 0;
    end else begin
      m_trk = 1; m_ox = clampc(ax - HALF); m_oy = clampc(ay - HALF);
    end
    chk("R8 upd", int'(upd), 1);
    chk("R2/R10 pk_score", int'(pk_score), bs);
    chk("R2/R5 pk_x", int'(pk_x), ax);
    chk("R2/R5 pk_y", int'(pk_y), ay);
    chk("R4/R6 win_x", int'(win_x), m_ox);
    chk("R4/R6 win_y", int'(win_y), m_oy);
    chk("R7 tracking", int'(tracking), m_trk);
    tick();
    chk("R8 upd single", int'(upd), 0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; frm_start = 0; frm_end = 0; smp_valid = 0; reacq = 0;
    thr_en = 0; min_score = '0; smp_x = '0; smp_y = '0; smp_score = '0;
    m_ox = LO; m_oy = LO; m_trk = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 win_x", int'(win_x), LO);
    chk("R1 win_y", int'(win_y), LO);
    chk("R1 tracking", int'(tracking), 0);
    chk("R1 upd", int'(upd), 0);
    chk("R1 pk_score", int'(pk_score), 0);

    // R4: acquisition over the whole array
    frame(16, 16, -1, -1, 200, 0, 0, 0);
    // R5: sweep every local peak position
    for (int py = 0; py < WIN; py++)
      for (int px = 0; px < WIN; px++)
        frame(px, py, -1, -1, 100 + px + py, 0, 0, 0);
    // R6: push to upper and lower clamps
    for (int i = 0; i < 12; i++) frame(4, 4, -1, -1, 150, 0, 0, 0);
    chk("R6 upper clamp x", int'(win_x), HI);
    for (int i = 0; i < 14; i++) frame(0, 0, -1, -1, 150, 0, 0, 0);
    chk("R6 lower clamp y", int'(win_y), LO);
    // R2: ties keep first in raster order
    frame(3, 1, 1, 3, 200, 200, 0, 0);
    frame(4, 2, 1, 2, 210, 210, 0, 0);
    // R3: lower peak in next frame replaces the previous one
    frame(2, 2, -1, -1, 40, 0, 0, 0);
    // R7: equal to threshold keeps tracking, below drops to acquisition
    frame(1, 1, -1, -1, 200, 0, 1, 200);
    frame(3, 3, -1, -1, 200, 0, 1, 201);
    chk("R7 dropped", int'(tracking), 0);
    // R4/R6: acquisition at corners
    frame(0, 0, -1, -1, 220, 0, 0, 0);
    frame(2, 2, -1, -1, 20, 0, 1, 250);
    frame(31, 31, -1, -1, 220, 0, 0, 0);
    chk("R6 acq clamp", int'(win_x), HI);

    // R9: reacq forces acquisition and wins over frm_end
    tick(); reacq = 1'b1;
    tick(); reacq = 1'b0;
    chk("R9 tracking", int'(tracking), 0);
    chk("R9 win_x", int'(win_x), m_ox);
    m_trk = 0;
    frame(5, 6, -1, -1, 230, 0, 0, 0);
    tick(); frm_start = 1'b1;
    tick(); frm_start = 1'b0; smp_valid = 1'b1; smp_x = 0; smp_y = 0; smp_score = 8'd99;
    tick(); smp_valid = 1'b0; frm_end = 1'b1; reacq = 1'b1;
    tick(); frm_end = 1'b0; reacq = 1'b0;
    chk("R9 no upd", int'(upd), 0);
    chk("R9 origin held", int'(win_y), m_oy);
    chk("R9 acq", int'(tracking), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule